// File: doc/BRIEF.md
# Conversion-start and data-gate sequencer

This block drives the two repeating timing strobes a fast serial-output successive-approximation converter needs. The first is a conversion-start pulse. Its rising edge starts the sampling of the analog input. The second is a gate window that lets the data clock run, so the result of a conversion is shifted out. Both signals repeat with one common period, and both are counted from the conversion rising edge. Every time is given in whole reference-clock cycles.

The period, conversion-high time, gate offset and gate length are taken from the configuration inputs when the sequencer starts, and they are held for the whole run. The requested period is first clamped into the legal range. A set that cannot fit inside that period is refused: the sequencer then reports an error and stays quiet. Each time a gate window closes, a one-cycle sample strobe tells a downstream capture stage that a complete word has arrived. When the gate offset is zero, the burst belongs to the conversion of the previous period. For that reason the first period after start carries no window.

Top module: `conv_gate_seq`

## Requirements
- R1: While reset is asserted, and in the cycles after reset until a start, conv_o, gate_o, sample_stb_o and cfg_err_o are all 0.
- R2: The period used is the requested period clamped to [MIN_PERIOD, MAX_PERIOD] (defaults 10 and 1000 cycles, that is 100 ns and 10 µs at 100 MHz). Validity is judged against the clamped value.
- R3: Run cycle k is the k-th cycle after the clock edge that sampled enable_i high while idle, counting from 0. In run cycle k, with phase c = k mod period, conv_o is 1 exactly when c < conversion-high time. The first pulse therefore starts in run cycle 0.
- R4: In run cycle k, gate_o is 1 exactly when gate offset <= c < gate offset + gate length.
- R5: When the gate offset is 0, no gate window opens during the first period of a run (k < period).
- R6: sample_stb_o is 1 for one cycle, in the run cycle right after the last cycle of each gate window (phase offset+length-1).
- R7: A set is rejected when any of these holds: conversion-high is 0, conversion-high >= period, length is 0, offset >= period, or offset+length > period. After a rejected start, cfg_err_o is 1 and the other outputs are 0 until enable_i is sampled low. In the cycle after that edge, cfg_err_o is 0.
- R8: Configuration inputs are captured only at start. Changing them during a run has no effect on the outputs.
- R9: When enable_i is sampled low during a run, the next cycle has gate_o and sample_stb_o at 0, while conv_o still follows its phase rule for that one cycle. In the cycle after that, all outputs are 0.
- R10: While the sequencer is idle, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; high starts, low stops |
| cfg_period_i | input | W | Requested period in cycles |
| cfg_conv_high_i | input | W | Conversion pulse high time in cycles |
| cfg_gate_off_i | input | W | Gate start offset from conversion edge in cycles |
| cfg_gate_len_i | input | W | Gate window length in cycles |
| conv_o | output | 1 | Conversion-start pulse |
| gate_o | output | 1 | Data clock gate window |
| sample_stb_o | output | 1 | One-cycle strobe after each window closes |
| cfg_err_o | output | 1 | Rejected configuration indicator |

## Verification
Every output is registered. The result of an enable or configuration change sampled at one rising edge is therefore due in the cycle right after that edge. The only exception is the stop sequence: the gate drops in the first cycle after the edge, and the conversion pulse drops one cycle later. The bench drives inputs on falling edges and queues the expected output word for the cycle after the coming rising edge. A monitor compares that word 2 ns after that rising edge. The expected words come from a phase model of the requirements, covering clamping, offset-zero skipping, windows that end on the period boundary, and the rejection rules.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2,
        ST_ERR  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/cgs_cfg_check.sv
module cgs_cfg_check #(
    parameter int W          = 16,
    parameter int MIN_PERIOD = 10,
    parameter int MAX_PERIOD = 1000
) (
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] high_i,
    input  logic [W-1:0] off_i,
    input  logic [W-1:0] len_i,
    output logic [W-1:0] period_o,
    output logic         valid_o
);
    localparam logic [W-1:0] MIN_C = W'(MIN_PERIOD);
    localparam logic [W-1:0] MAX_C = W'(MAX_PERIOD);

    logic [W:0] end_w;

    always_comb begin
        if (period_i < MIN_C) begin
            period_o = MIN_C;
        end else if (period_i > MAX_C) begin
            period_o = MAX_C;
        end else begin
            period_o = period_i;
        end
        end_w   = {1'b0, off_i} + {1'b0, len_i};
        valid_o = (high_i != '0) && (high_i < period_o) &&
                  (len_i != '0) && (off_i < period_o) &&
                  (end_w <= {1'b0, period_o});
    end
endmodule

// File: rtl/cgs_phase.sv
module cgs_phase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         adv_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_d_o,
    output logic [W-1:0] cnt_q_o,
    output logic         prim_d_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         prim;
    } phase_t;

    phase_t r_q, r_d;
    logic   wrap;

    always_comb begin
        r_d  = r_q;
        wrap = (r_q.cnt == period_i - W'(1));
        if (start_i) begin
            r_d.cnt  = '0;
            r_d.prim = 1'b1;
        end else if (adv_i) begin
            r_d.cnt  = wrap ? '0 : r_q.cnt + W'(1);
            r_d.prim = r_q.prim && !wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_d_o  = r_d.cnt;
    assign cnt_q_o  = r_q.cnt;
    assign prim_d_o = r_d.prim;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (r_q.cnt < period_i)); // R2
endmodule

// File: rtl/cgs_gate.sv
module cgs_gate #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_d_i,
    input  logic         run_q_i,
    input  logic [W-1:0] cnt_d_i,
    input  logic [W-1:0] cnt_q_i,
    input  logic         prim_d_i,
    input  logic [W-1:0] off_i,
    input  logic [W-1:0] len_i,
    output logic         gate_o,
    output logic         stb_o
);
    typedef struct packed {
        logic gate;
        logic stb;
    } gate_t;

    gate_t      r_q, r_d;
    logic [W:0] end_w;
    logic [W:0] last_w;
    logic       in_win;

    always_comb begin
        end_w    = {1'b0, off_i} + {1'b0, len_i};
        last_w   = end_w - (W+1)'(1);
        in_win   = (cnt_d_i >= off_i) && ({1'b0, cnt_d_i} < end_w);
        r_d.gate = run_d_i && in_win && !(prim_d_i && (off_i == '0));
        r_d.stb  = run_q_i && run_d_i && r_q.gate && ({1'b0, cnt_q_i} == last_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o = r_q.gate;
    assign stb_o  = r_q.stb;

    AST_STB_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stb |-> $past(r_q.gate)); // R6
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stb |=> !r_q.stb); // R6
endmodule

// File: rtl/conv_gate_seq.sv
module conv_gate_seq #(
    parameter int W          = 16,
    parameter int MIN_PERIOD = 10,
    parameter int MAX_PERIOD = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic [W-1:0] cfg_period_i,
    input  logic [W-1:0] cfg_conv_high_i,
    input  logic [W-1:0] cfg_gate_off_i,
    input  logic [W-1:0] cfg_gate_len_i,
    output logic         conv_o,
    output logic         gate_o,
    output logic         sample_stb_o,
    output logic         cfg_err_o
);
    import cgs_pkg::*;

    typedef struct packed {
        logic [W-1:0] period;
        logic [W-1:0] high;
        logic [W-1:0] off;
        logic [W-1:0] len;
    } cfg_t;

    typedef struct packed {
        seq_state_e st;
        cfg_t       cfg;
        logic       conv;
        logic       err;
    } top_t;

    top_t         r_q, r_d;
    logic         start;
    logic [W-1:0] chk_period;
    logic         chk_valid;
    logic [W-1:0] cnt_d, cnt_q;
    logic         prim_d;

    cgs_cfg_check #(.W(W), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)) u_check (
        .period_i (cfg_period_i),
        .high_i   (cfg_conv_high_i),
        .off_i    (cfg_gate_off_i),
        .len_i    (cfg_gate_len_i),
        .period_o (chk_period),
        .valid_o  (chk_valid)
    );

    cgs_phase #(.W(W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .adv_i    (r_q.st == ST_RUN),
        .period_i (r_q.cfg.period),
        .cnt_d_o  (cnt_d),
        .cnt_q_o  (cnt_q),
        .prim_d_o (prim_d)
    );

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (enable_i) begin
                    if (chk_valid) begin
                        r_d.st         = ST_RUN;
                        r_d.cfg.period = chk_period;
                        r_d.cfg.high   = cfg_conv_high_i;
                        r_d.cfg.off    = cfg_gate_off_i;
                        r_d.cfg.len    = cfg_gate_len_i;
                        start          = 1'b1;
                    end else begin
                        r_d.st = ST_ERR;
                    end
                end
            end
            ST_RUN:  if (!enable_i) r_d.st = ST_STOP;
            ST_STOP: r_d.st = ST_IDLE;
            ST_ERR:  if (!enable_i) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        r_d.conv = ((r_d.st == ST_RUN) || (r_d.st == ST_STOP)) && (cnt_d < r_d.cfg.high);
        r_d.err  = (r_d.st == ST_ERR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cfg: '0, conv: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    cgs_gate #(.W(W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_d_i  (r_d.st == ST_RUN),
        .run_q_i  (r_q.st == ST_RUN),
        .cnt_d_i  (cnt_d),
        .cnt_q_i  (cnt_q),
        .prim_d_i (prim_d),
        .off_i    (r_d.cfg.off),
        .len_i    (r_d.cfg.len),
        .gate_o   (gate_o),
        .stb_o    (sample_stb_o)
    );

    assign conv_o    = r_q.conv;
    assign cfg_err_o = r_q.err;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !(conv_o || gate_o || sample_stb_o || cfg_err_o)); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !(conv_o || gate_o || sample_stb_o)); // R7
    AST_STOP_GATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STOP) |-> !(gate_o || sample_stb_o)); // R9
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RUN) && ($past(r_q.st) == ST_RUN)) |-> $stable(r_q.cfg)); // R8
    AST_PERIOD_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> ((r_q.cfg.period >= W'(MIN_PERIOD)) &&
                                (r_q.cfg.period <= W'(MAX_PERIOD)))); // R2
    AST_FIRST_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_RUN) |-> conv_o); // R3
endmodule

// File: tb/conv_gate_seq_tb_top.sv
module conv_gate_seq_tb_top;
    localparam int W    = 16;
    localparam int PMIN = 10;
    localparam int PMAX = 1000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         enable;
    logic [W-1:0] cfg_period, cfg_high, cfg_off, cfg_len;
    logic         conv_o, gate_o, sample_stb_o, cfg_err_o;

    int total = 0;
    int bad   = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    conv_gate_seq #(.W(W), .MIN_PERIOD(PMIN), .MAX_PERIOD(PMAX)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable_i        (enable),
        .cfg_period_i    (cfg_period),
        .cfg_conv_high_i (cfg_high),
        .cfg_gate_off_i  (cfg_off),
        .cfg_gate_len_i  (cfg_len),
        .conv_o          (conv_o),
        .gate_o          (gate_o),
        .sample_stb_o    (sample_stb_o),
        .cfg_err_o       (cfg_err_o)
    );

    task automatic push(input bit c, input bit g, input bit s, input bit e, input string tag);
        exp_q.push_back({c, g, s, e});
        tag_q.push_back(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({conv_o, gate_o, sample_stb_o, cfg_err_o} !== e) begin
                    bad++;
                    $display("FAIL %s: conv/gate/stb/err got %b expected %b at %0t",
                             t, {conv_o, gate_o, sample_stb_o, cfg_err_o}, e, $time);
                end
            end
        end
    end

    function automatic bit win(int c, int k, int p, int off, int len);
        return (c >= off) && (c < off + len) && !((k < p) && (off == 0));
    endfunction

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push(0, 0, 0, 0, tag);
        end
    endtask

    task automatic run(input int preq, input int h, input int off, input int len,
                       input int n, input bit midchg, input string force_tag);
        int p;
        p = (preq < PMIN) ? PMIN : ((preq > PMAX) ? PMAX : preq);
        for (int k = 0; k < n; k++) begin
            bit    ec, eg, es;
            int    c;
            string t;
            @(negedge clk);
            if (k == 0) begin
                cfg_period = W'(preq); cfg_high = W'(h);
                cfg_off    = W'(off);  cfg_len  = W'(len);
                enable     = 1'b1;
            end
            if (midchg && k == n / 2) begin
                cfg_period = 16'd13; cfg_high = 16'd1; cfg_off = 16'd2; cfg_len = 16'd3;
            end
            c  = k % p;
            ec = (c < h);
            eg = win(c, k, p, off, len);
            es = (k >= 1) && win((k - 1) % p, k - 1, p, off, len) &&
                 (((k - 1) % p) == off + len - 1);
            if (force_tag != "")          t = force_tag;
            else if (es)                  t = "R6";
            else if (off == 0 && k < p)   t = "R5";
            else if (eg)                  t = "R4";
            else                          t = "R3";
            push(ec, eg, es, 0, t);
        end
        @(negedge clk);
        enable = 1'b0;
        push((n % p) < h, 0, 0, 0, "R9");
        idle(2, "R9");
    endtask

    task automatic reject(input int preq, input int h, input int off, input int len, input int n);
        @(negedge clk);
        cfg_period = W'(preq); cfg_high = W'(h); cfg_off = W'(off); cfg_len = W'(len);
        enable = 1'b1;
        push(0, 0, 0, 1, "R7");
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            push(0, 0, 0, 1, "R7");
        end
        @(negedge clk);
        enable = 1'b0;
        push(0, 0, 0, 0, "R7");
        idle(1, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected run completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0;
        cfg_period = '0; cfg_high = '0; cfg_off = '0; cfg_len = '0;
        repeat (3) @(negedge clk);
        total++;
        if ({conv_o, gate_o, sample_stb_o, cfg_err_o} !== 4'b0) begin
            bad++;
            $display("FAIL R1: outputs in reset got %b expected 0000",
                     {conv_o, gate_o, sample_stb_o, cfg_err_o});
        end
        rst_n = 1'b1;
        idle(4, "R1");
        run(20, 4, 14, 5, 70, 0, "");          // R3 R4 R6 nominal
        idle(3, "R10");
        run(12, 8, 0, 12, 50, 0, "");          // R5 window spans whole period
        run(24, 3, 0, 16, 60, 0, "");          // R5 offset zero, shorter burst
        run(3, 2, 3, 4, 35, 0, "R2");          // clamp up to minimum
        run(2000, 4, 990, 10, 2100, 0, "R2");  // clamp down to maximum
        run(20, 5, 2, 6, 80, 1, "R8");         // mid-run config change ignored
        reject(20, 4, 10, 11, 8);              // R7 window past period
        reject(20, 0, 2, 3, 5);                // R7 zero high time
        reject(20, 4, 20, 1, 5);               // R7 offset equals period
        reject(20, 20, 2, 3, 4);               // R7 high equals period
        run(10, 1, 9, 1, 30, 0, "");           // R6 window ends on period boundary
        idle(3, "R10");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule